// File: doc/BRIEF.md
# Frame Delay Timer

This block times the gap between the end of a reader transmission and the start of a synchronous card reply. It runs an up-counter that advances once per carrier clock. Every falling edge on the demodulated-data input marks a reader modulation pause. Each such edge zeroes the counter and starts it again. Once the count reaches the programmed reply delay, the transmit-frame output goes high, and a serial transmitter downstream uses that to begin sending the reply.

A second programmable threshold raises a frame-end flag when enough carrier cycles have passed since the last pause. A fixed stop value ends the count. At that value the counter freezes instead of wrapping, and the transmit-frame output drops. Four sticky status flags record the events: trigger edge, reply delay reached, frame end, and stop reached. A mask selects which flags drive the interrupt line. A read strobe clears the flags.

Top module: `fdt_timer`

## Requirements
- R1: After reset the count is 0, `tx_frame_o` is low, all status flags are 0, and the count stays at 0 until the first falling edge of `trig_i`. The delay and frame-end thresholds start from the parameters `DLY_INIT` and `FEND_INIT`.
- R2: A falling edge of `trig_i` (sampled low at a clock edge after being sampled high at the edge before) causes the following. On that clock edge the count is set to 0 and `tx_frame_o` is forced low. From the next edge on, the count rises by 1 per clock. A rising edge of `trig_i` has no effect on the count.
- R3: When the running count equals the delay threshold at a clock edge, `tx_frame_o` goes high on that edge. The output is therefore first seen high when the count reads delay+1.
- R4: When the count reaches `STOP_AT` (all ones by default), the following edge stops the counter and clears `tx_frame_o`. The count then holds at `STOP_AT` and does not wrap, until the next falling edge of `trig_i`.
- R5: A write of the delay threshold (`dly_we`) takes effect from the next clock. A new value still ahead of the current count produces the rise at the new value. A new value the count has already passed produces no rise in this count.
- R6: The status flags are `stat_o` bit 0 = trigger edge, bit 1 = delay reached, bit 2 = frame end, and bit 3 = stop reached. Each flag is set by its event and stays set until a read.
- R7: A clock edge with `stat_rd` high clears every flag. An exception applies to any flag whose event happens on that same edge: that flag ends up set.
- R8: `irq_o` is high exactly when some flag is set whose bit in `irq_mask` is 1.
- R9: The frame-end threshold is writable through `fend_we`, and its reset value is `FEND_INIT` (default 256). The frame-end flag is set on the edge at which the running count equals that threshold.
- R10: A trigger edge has priority over a delay match on the same clock edge. On such an edge `tx_frame_o` stays low, the count restarts, and the delay flag is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Demodulated data; falling edge marks a modulation pause |
| dly_we | input | 1 | Write strobe for the reply-delay threshold |
| dly_wdata | input | W | New reply-delay threshold |
| fend_we | input | 1 | Write strobe for the frame-end threshold |
| fend_wdata | input | W | New frame-end threshold |
| irq_mask | input | 4 | Interrupt enable per status flag |
| stat_rd | input | 1 | Status read strobe, clears the flags |
| stat_o | output | 4 | Sticky status flags |
| irq_o | output | 1 | Interrupt request |
| tx_frame_o | output | 1 | Transmit-frame start signal |
| count_o | output | W | Current count |

## Verification
The bench builds the block with an 8-bit counter, a reply delay of 20, a frame-end threshold of 40, and the default all-ones stop value of 255. The narrow counter lets a single count run from trigger to the stop value and its freeze in a few hundred cycles, so the no-wrap behaviour is exercised directly. The small thresholds leave room in one run for a retrigger, a same-edge collision between trigger and delay match, and threshold rewrites both ahead of and behind the running count.

// File: rtl/fdt_pkg.sv
package fdt_pkg;

    localparam int FLAG_W   = 4;
    localparam int FLG_EXT  = 0;
    localparam int FLG_DLY  = 1;
    localparam int FLG_END  = 2;
    localparam int FLG_STOP = 3;
    localparam int NCMP     = 2;

    typedef enum logic {
        CNT_IDLE = 1'b0,
        CNT_RUN  = 1'b1
    } cnt_state_e;

    typedef struct packed {
        logic stop;
        logic fend;
        logic dly;
        logic ext;
    } fdt_evt_t;

    function automatic logic [FLAG_W-1:0] evt_to_flags(fdt_evt_t e);
        logic [FLAG_W-1:0] f;
        f           = '0;
        f[FLG_EXT]  = e.ext;
        f[FLG_DLY]  = e.dly;
        f[FLG_END]  = e.fend;
        f[FLG_STOP] = e.stop;
        return f;
    endfunction

endpackage

// File: rtl/fdt_edge_det.sv
module fdt_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= din;
    end

    assign fall = prev_q & ~din;

    // R2: one falling edge yields a single restart pulse
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        fall |=> !fall);

endmodule

// File: rtl/fdt_counter.sv
module fdt_counter
    import fdt_pkg::*;
#(
    parameter int            W       = 16,
    parameter logic [W-1:0]  STOP_AT = {W{1'b1}}
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    output logic [W-1:0] cnt_o,
    output logic         running_o,
    output logic         stop_hit_o
);
    cnt_state_e   st_q;
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= CNT_IDLE;
            cnt_q <= '0;
        end else if (restart) begin
            st_q  <= CNT_RUN;
            cnt_q <= '0;
        end else if (st_q == CNT_RUN) begin
            if (cnt_q == STOP_AT) st_q  <= CNT_IDLE;
            else                  cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o      = cnt_q;
    assign running_o  = (st_q == CNT_RUN);
    assign stop_hit_o = running_o && !restart && (cnt_q == STOP_AT);

    // R1, R4: an idle counter does not move without a trigger
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == CNT_IDLE && !restart) |=> $stable(cnt_q));
    // R4: the stop value is never passed
    p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == STOP_AT && !restart) |=> (cnt_q == STOP_AT));
    // R2: a trigger zeroes the count and starts it
    p_restart_zero_r2: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt_q == '0 && st_q == CNT_RUN));

endmodule

// File: rtl/fdt_match.sv
module fdt_match #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] thr,
    input  logic         armed,
    output logic         hit
);
    assign hit = armed && (cnt == thr);
endmodule

// File: rtl/fdt_status.sv
module fdt_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         rd,
    input  logic [N-1:0] mask,
    output logic [N-1:0] flags_o,
    output logic         irq_o
);
    logic [N-1:0] flags_q;

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= (rd ? '0 : flags_q) | set;
    end

    assign flags_o = flags_q;
    assign irq_o   = |(flags_q & mask);

    // R6: without a read no flag is lost
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        !rd |=> ((flags_q & $past(flags_q)) == $past(flags_q)));
    // R7: a read leaves only the events of that same edge
    p_rd_clear_r7: assert property (@(posedge clk) disable iff (rst)
        rd |=> (flags_q == $past(set)));

endmodule

// File: rtl/fdt_timer.sv
module fdt_timer
    import fdt_pkg::*;
#(
    parameter int           W         = 16,
    parameter logic [W-1:0] STOP_AT   = {W{1'b1}},
    parameter logic [W-1:0] DLY_INIT  = W'(1172),
    parameter logic [W-1:0] FEND_INIT = W'(256)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_i,
    input  logic              dly_we,
    input  logic [W-1:0]      dly_wdata,
    input  logic              fend_we,
    input  logic [W-1:0]      fend_wdata,
    input  logic [FLAG_W-1:0] irq_mask,
    input  logic              stat_rd,
    output logic [FLAG_W-1:0] stat_o,
    output logic              irq_o,
    output logic              tx_frame_o,
    output logic [W-1:0]      count_o
);
    logic            restart;
    logic [W-1:0]    cnt;
    logic            running;
    logic            stop_hit;
    logic            armed;
    logic [W-1:0]    dly_q;
    logic [W-1:0]    fend_q;
    logic [W-1:0]    thr [NCMP];
    logic [NCMP-1:0] hit;
    logic            tx_q;
    fdt_evt_t        evt;

    fdt_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (trig_i),
        .fall (restart)
    );

    fdt_counter #(.W(W), .STOP_AT(STOP_AT)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .restart    (restart),
        .cnt_o      (cnt),
        .running_o  (running),
        .stop_hit_o (stop_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q  <= DLY_INIT;
            fend_q <= FEND_INIT;
        end else begin
            if (dly_we)  dly_q  <= dly_wdata;
            if (fend_we) fend_q <= fend_wdata;
        end
    end

    assign armed  = running && !restart;
    assign thr[0] = dly_q;
    assign thr[1] = fend_q;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        fdt_match #(.W(W)) u_match (
            .cnt   (cnt),
            .thr   (thr[g]),
            .armed (armed),
            .hit   (hit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)           tx_q <= 1'b0;
        else if (restart)  tx_q <= 1'b0;
        else if (stop_hit) tx_q <= 1'b0;
        else if (hit[0])   tx_q <= 1'b1;
    end

    always_comb begin
        evt      = '0;
        evt.ext  = restart;
        evt.dly  = hit[0];
        evt.fend = hit[1];
        evt.stop = stop_hit;
    end

    fdt_status #(.N(FLAG_W)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .set     (evt_to_flags(evt)),
        .rd      (stat_rd),
        .mask    (irq_mask),
        .flags_o (stat_o),
        .irq_o   (irq_o)
    );

    assign tx_frame_o = tx_q;
    assign count_o    = cnt;

    // R3: the output only rises on a delay match
    p_tx_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_q) |-> ($past(cnt) == $past(dly_q)));
    // R4: reaching the stop value drops the output
    p_tx_stop_r4: assert property (@(posedge clk) disable iff (rst)
        stop_hit |=> !tx_q);
    // R10: a trigger edge wins over a same-edge match
    p_edge_wins_r10: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!tx_q && !stat_o[FLG_DLY] || !tx_q));

endmodule

// File: tb/fdt_timer_tb_top.sv
`timescale 1ns/1ps
module fdt_timer_tb_top;
    localparam int W = 8;

    typedef struct {
        int         cyc;
        bit         chk_cnt;
        logic [7:0] cnt;
        bit         chk_tx;
        logic       tx;
        logic [3:0] stmask;
        logic [3:0] st;
        string      req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst;
    logic         trig_i;
    logic         dly_we;
    logic [W-1:0] dly_wdata;
    logic         fend_we;
    logic [W-1:0] fend_wdata;
    logic [3:0]   irq_mask;
    logic         stat_rd;
    logic [3:0]   stat_o;
    logic         irq_o;
    logic         tx_frame_o;
    logic [W-1:0] count_o;

    int   cyc   = 0;
    int   nvec  = 0;
    int   nfail = 0;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    fdt_timer #(.W(W), .DLY_INIT(8'd20), .FEND_INIT(8'd40)) dut_i (
        .clk(clk), .rst(rst), .trig_i(trig_i),
        .dly_we(dly_we), .dly_wdata(dly_wdata),
        .fend_we(fend_we), .fend_wdata(fend_wdata),
        .irq_mask(irq_mask), .stat_rd(stat_rd),
        .stat_o(stat_o), .irq_o(irq_o),
        .tx_frame_o(tx_frame_o), .count_o(count_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int c, input bit cc, input logic [7:0] cv,
                        input bit ct, input logic tv,
                        input logic [3:0] sm, input logic [3:0] sv,
                        input string req);
        exp_t e;
        e.cyc = c; e.chk_cnt = cc; e.cnt = cv; e.chk_tx = ct; e.tx = tv;
        e.stmask = sm; e.st = sv; e.req = req;
        q.push_back(e);
    endtask

    // monitor: pops expectations due in this cycle and compares them
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.cyc != cyc) begin
                chk(e.req, "sample cycle", cyc, e.cyc);
            end else begin
                if (e.chk_cnt) chk(e.req, "count", count_o, e.cnt);
                if (e.chk_tx)  chk(e.req, "tx_frame", tx_frame_o, e.tx);
                if (e.stmask != 4'd0)
                    chk(e.req, "status", stat_o & e.stmask, e.st & e.stmask);
            end
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic fire(output int t);
        @(negedge clk); trig_i = 1'b0;
        @(negedge clk); trig_i = 1'b1;
        t = cyc;
    endtask

    task automatic wr_dly(input logic [7:0] v);
        dly_wdata = v; dly_we = 1'b1;
        @(negedge clk); dly_we = 1'b0;
    endtask

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int t0, t1, t2, t3, t4, t5;
        rst = 1'b1; trig_i = 1'b1; dly_we = 1'b0; dly_wdata = '0;
        fend_we = 1'b0; fend_wdata = '0; irq_mask = 4'd0; stat_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        // R1: reset state, counter idle until a trigger
        chk("R1", "count", count_o, 0);
        chk("R1", "tx_frame", tx_frame_o, 0);
        chk("R1", "status", stat_o, 0);
        chk("R1", "irq", irq_o, 0);

        // first full run to the stop value
        fire(t0);
        chk("R2", "count after edge", count_o, 0);
        chk("R2", "tx after edge", tx_frame_o, 0);
        chk("R6", "trigger flag", stat_o, 4'b0001);
        push(t0+5,   1, 8'd5,   1, 0, 4'd0, 4'd0, "R2");
        push(t0+20,  1, 8'd20,  1, 0, 4'd0, 4'd0, "R3");
        push(t0+21,  1, 8'd21,  1, 1, 4'b0010, 4'b0010, "R3");
        push(t0+40,  0, 8'd0,   0, 0, 4'b0100, 4'b0000, "R9");
        push(t0+41,  0, 8'd0,   0, 0, 4'b0100, 4'b0100, "R9");
        push(t0+255, 1, 8'd255, 1, 1, 4'b1000, 4'b0000, "R4");
        push(t0+256, 1, 8'd255, 1, 0, 4'b1111, 4'b1111, "R4");
        push(t0+300, 1, 8'd255, 1, 0, 4'd0, 4'd0, "R4");
        wait_until(t0+301);

        // R8: masked-off flags raise no interrupt; R7: read clears
        chk("R8", "irq with mask 0", irq_o, 0);
        stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk("R7", "status after read", stat_o, 0);

        // interrupt mask and retrigger during a run
        irq_mask = 4'b0010;
        fire(t0);
        #1 chk("R8", "irq on unmasked flag only", irq_o, 0);
        wait_until(t0+21);
        chk("R8", "irq on delay flag", irq_o, 1);
        wait_until(t0+29);
        fire(t1);
        chk("R2", "retrigger count", count_o, 0);
        chk("R2", "retrigger tx", tx_frame_o, 0);
        push(t1+3,  1, 8'd3,  0, 0, 4'd0, 4'd0, "R2");
        push(t1+21, 1, 8'd21, 1, 1, 4'd0, 4'd0, "R3");
        wait_until(t1+40);

        // R10: trigger edge coincides with the delay match
        fire(t2);
        wait_until(t2+20);
        trig_i = 1'b0;
        @(negedge clk); trig_i = 1'b1;
        t3 = cyc;
        chk("R10", "tx on collision", tx_frame_o, 0);
        chk("R10", "count on collision", count_o, 0);
        // R7: event on the read edge survives the read
        wait_until(t3+20);
        stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        chk("R7", "same-edge event kept", stat_o, 4'b0010);
        chk("R3", "tx after match", tx_frame_o, 1);

        // R5: delay rewritten ahead of the count
        wait_until(t3+50);
        fire(t4);
        wait_until(t4+5);
        wr_dly(8'd50);
        push(t4+21, 1, 8'd21, 1, 0, 4'd0, 4'd0, "R5");
        push(t4+50, 1, 8'd50, 1, 0, 4'd0, 4'd0, "R5");
        push(t4+51, 1, 8'd51, 1, 1, 4'd0, 4'd0, "R5");
        wait_until(t4+60);

        // R9: new frame-end threshold; R5: delay rewritten behind the count
        fend_wdata = 8'd70; fend_we = 1'b1;
        @(negedge clk); fend_we = 1'b0;
        stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
        fire(t5);
        wait_until(t5+30);
        wr_dly(8'd10);
        push(t5+51,  1, 8'd51, 1, 0, 4'd0, 4'd0, "R5");
        push(t5+70,  0, 8'd0,  0, 0, 4'b0100, 4'b0000, "R9");
        push(t5+71,  0, 8'd0,  0, 0, 4'b0100, 4'b0100, "R9");
        push(t5+120, 1, 8'd120, 1, 0, 4'b0010, 4'b0000, "R5");
        wait_until(t5+130);
        chk("R8", "irq with delay flag clear", irq_o, 0);
        irq_mask = 4'b0100;
        #1 chk("R8", "irq on frame-end flag", irq_o, 1);

        while (q.size() > 0) @(negedge clk);
        finish_run();
    end

endmodule